// File: doc/BRIEF.md
# Integer Execution Unit with Byte-Address Adder

This block is the arithmetic and logic stage of a small 32-bit integer core. It has no state. A 4-bit operation code and two 32-bit operands go in. A 32-bit result and a single-bit compare flag come out in the same cycle.

The operation code is built from two parts:

- The low three bits repeat the instruction's funct3 field, with this mapping:
  - 000: add, or subtract when bit 3 is set
  - 001: shift left
  - 010: signed set-less-than
  - 011: unsigned set-less-than
  - 100: exclusive-or
  - 101: right shift, arithmetic when bit 3 is set
  - 110: or
  - 111: and
- Bit 3 selects the alternate form of the operation.

Conditional branches use the same code space and read the flag. Code 1000 raises the flag on equal operands. Codes 1010 and 1011 raise it on signed and unsigned less-than. The decoder inverts the flag for the not-equal and greater-or-equal branches. An upper-immediate-plus-PC operation is issued as a plain add: the immediate goes on operand 1 and the byte PC on operand 2.

A second, independent adder sums two 20-bit inputs into a 20-bit byte address. It wraps modulo 2^20 and serves jump targets, branch targets and load/store addresses.

Top module: `int_exec_unit`

## Requirements
- R1: Code 0000 drives the 32-bit sum of operand 1 and operand 2, taken modulo 2^32, and the flag is low.
- R2: Code 1000 drives operand 1 minus operand 2, taken modulo 2^32. The flag is high exactly when the two operands are equal.
- R3: Codes 0010 and 1010 compare the operands as signed two's-complement values. The flag is 1 when operand 1 < operand 2, and the result is that same bit zero-extended to 32 bits.
- R4: Codes 0011 and 1011 do the same comparison with the operands taken as unsigned values. The flag and the zero-extended result follow the unsigned less-than outcome.
- R5: Codes x100, x110 and x111 give bitwise XOR, OR and AND of the operands. Bit 3 has no effect on these codes.
- R6: Codes 0001 and 1001 shift operand 1 left by operand 2 bits [4:0], filling with zeros. Operand 2 bits [31:5] are ignored.
- R7: Code 0101 shifts operand 1 right with zero fill. Code 1101 shifts it right with copies of operand 1 bit 31. In both cases the amount is operand 2 bits [4:0].
- R8: For every code other than 1000, x010 and x011, the flag is low.
- R9: The address output equals address input A plus address input B modulo 2^20, whatever the operation code and the data operands.
- R10: Every output settles from the current inputs alone, with no clock and no retained state. The same inputs always give the same outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | operation select: bit 3 picks the alternate form, bits [2:0] are the funct3 field |
| opnd_a | input | 32 | operand 1 |
| opnd_b | input | 32 | operand 2; bits [4:0] give the shift amount |
| addr_a | input | 20 | first address addend |
| addr_b | input | 20 | second address addend |
| result | output | 32 | arithmetic, logic, shift or set-less-than result |
| flag | output | 1 | equality or less-than outcome used by branches |
| addr_sum | output | 20 | wrapped 20-bit byte address |

## Verification
The block keeps no state, so any fault shows at the ports in the same cycle as the stimulus that exposes it. A mis-steered select line gives a wrong result for one code and a correct one for its neighbours. A broken carry or sign path shows only on boundary operands, such as the most negative value against the most positive, or a shift of 31. Each operand pair is therefore applied to every code. Each output is compared with a model written from the requirements in the next sample slot.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

    localparam int OP_W = 4;

    typedef enum logic [2:0] {
        FN_ADD  = 3'd0,
        FN_SHL  = 3'd1,
        FN_SLT  = 3'd2,
        FN_SLTU = 3'd3,
        FN_XOR  = 3'd4,
        FN_SHR  = 3'd5,
        FN_OR   = 3'd6,
        FN_AND  = 3'd7
    } funct_e;

endpackage

// File: rtl/exec_shifter.sv
module exec_shifter #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          to_left,
    input  logic          arith,
    output logic [W-1:0]  dout
);
    logic [W-1:0] flip_in;
    logic [W-1:0] shr_d;
    logic         fill;

    // A left shift is a right shift of the bit-reversed word.
    for (genvar i = 0; i < W; i++) begin : g_flip_in
        assign flip_in[i] = to_left ? din[W-1-i] : din[i];
    end

    assign fill = arith & ~to_left & din[W-1];

    always_comb begin
        shr_d = flip_in;
        for (int s = 0; s < SW; s++) begin
            if (amt[s]) begin
                shr_d = (shr_d >> (1 << s)) |
                        ({W{fill}} & ~({W{1'b1}} >> (1 << s)));
            end
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_flip_out
        assign dout[i] = to_left ? shr_d[W-1-i] : shr_d[i];
    end
endmodule

// File: rtl/exec_compare.sv
module exec_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic         is_eq,
    output logic         lt_signed,
    output logic         lt_unsigned
);
    logic [W:0] diff_d;
    logic       sign_differs;

    // One wide subtract serves both less-than forms.
    always_comb begin
        diff_d       = {1'b0, lhs} - {1'b0, rhs};
        sign_differs = lhs[W-1] ^ rhs[W-1];
        is_eq        = (lhs == rhs);
        lt_unsigned  = diff_d[W];
        lt_signed    = sign_differs ? lhs[W-1] : diff_d[W-1];
    end
endmodule

// File: rtl/exec_addr_adder.sv
module exec_addr_adder #(
    parameter int AW = 20
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] ofs,
    output logic [AW-1:0] sum
);
    assign sum = base + ofs;

    always_comb begin
        AST_ADDR_WRAP: assert ((sum - ofs) == base); // R9
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 20
) (
    input  logic [int_exec_pkg::OP_W-1:0] op_code,
    input  logic [DATA_W-1:0]             opnd_a,
    input  logic [DATA_W-1:0]             opnd_b,
    input  logic [ADDR_W-1:0]             addr_a,
    input  logic [ADDR_W-1:0]             addr_b,
    output logic [DATA_W-1:0]             result,
    output logic                          flag,
    output logic [ADDR_W-1:0]             addr_sum
);
    import int_exec_pkg::*;

    localparam int SHAMT_W = $clog2(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              flag;
    } exec_out_t;

    funct_e            funct;
    logic              alt;
    logic [DATA_W-1:0] addsub;
    logic [DATA_W-1:0] shift_out;
    logic              eq, lt_s, lt_u;
    exec_out_t         out_d;

    assign funct  = funct_e'(op_code[2:0]);
    assign alt    = op_code[OP_W-1];
    assign addsub = alt ? (opnd_a - opnd_b) : (opnd_a + opnd_b);

    exec_shifter #(.W(DATA_W), .SW(SHAMT_W)) i_shift (
        .din     (opnd_a),
        .amt     (opnd_b[SHAMT_W-1:0]),
        .to_left (funct == FN_SHL),
        .arith   (alt),
        .dout    (shift_out)
    );

    exec_compare #(.W(DATA_W)) i_cmp (
        .lhs         (opnd_a),
        .rhs         (opnd_b),
        .is_eq       (eq),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    exec_addr_adder #(.AW(ADDR_W)) i_addr (
        .base (addr_a),
        .ofs  (addr_b),
        .sum  (addr_sum)
    );

    always_comb begin
        out_d = '0;
        unique case (funct)
            FN_ADD:  begin
                out_d.value = addsub;
                out_d.flag  = alt & eq;
            end
            FN_SHL, FN_SHR: out_d.value = shift_out;
            FN_SLT:  begin
                out_d.value = {{(DATA_W-1){1'b0}}, lt_s};
                out_d.flag  = lt_s;
            end
            FN_SLTU: begin
                out_d.value = {{(DATA_W-1){1'b0}}, lt_u};
                out_d.flag  = lt_u;
            end
            FN_XOR:  out_d.value = opnd_a ^ opnd_b;
            FN_OR:   out_d.value = opnd_a | opnd_b;
            FN_AND:  out_d.value = opnd_a & opnd_b;
            default: out_d = '0;
        endcase
    end

    assign result = out_d.value;
    assign flag   = out_d.flag;

    always_comb begin
        if (op_code == {1'b1, FN_ADD}) begin
            AST_SUB_EQUAL: assert (flag == (result == '0)); // R2
        end
        if (funct == FN_SLT || funct == FN_SLTU) begin
            AST_SET_BINARY: assert (result[DATA_W-1:1] == '0 && result[0] == flag); // R3
        end
        if (op_code == {1'b1, FN_SHR}) begin
            AST_SRA_SIGN: assert (result[DATA_W-1] == opnd_a[DATA_W-1]); // R7
        end
        if (funct != FN_SLT && funct != FN_SLTU && op_code != {1'b1, FN_ADD}) begin
            AST_FLAG_QUIET: assert (!flag); // R8
        end
    end
endmodule

// File: tb/test_int_exec_unit.sv
module test_int_exec_unit;
    localparam int DW = 32;
    localparam int AW = 20;

    typedef struct {
        logic [DW-1:0] res;
        logic          flg;
        logic [AW-1:0] asum;
        logic [3:0]    op;
        string         req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    op_code = '0;
    logic [DW-1:0] opnd_a = '0, opnd_b = '0;
    logic [AW-1:0] addr_a = '0, addr_b = '0;
    logic [DW-1:0] result;
    logic          flag;
    logic [AW-1:0] addr_sum;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    item_t sb[$];

    always #10 clk = ~clk;

    int_exec_unit i_int_exec_unit (
        .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .addr_a(addr_a), .addr_b(addr_b),
        .result(result), .flag(flag), .addr_sum(addr_sum)
    );

    function automatic string req_of(logic [3:0] op);
        case (op[2:0])
            3'd0: return op[3] ? "R2" : "R1,R8";
            3'd1: return "R6,R8";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd5: return "R7,R8";
            default: return "R5,R8";
        endcase
    endfunction

    task automatic model(input logic [3:0] op, input logic [DW-1:0] a, b,
                         output logic [DW-1:0] r, output logic f);
        logic [4:0] sh;
        sh = b[4:0];
        f = 1'b0;
        case (op[2:0])
            3'd0: begin
                r = op[3] ? a - b : a + b;
                f = op[3] && (a == b);
            end
            3'd1: r = a << sh;
            3'd2: begin f = $signed(a) < $signed(b); r = {31'b0, f}; end
            3'd3: begin f = a < b; r = {31'b0, f}; end
            3'd4: r = a ^ b;
            3'd5: r = op[3] ? DW'($signed(a) >>> sh) : a >> sh;
            3'd6: r = a | b;
            default: r = a & b;
        endcase
    endtask

    task automatic apply(input logic [3:0] op, input logic [DW-1:0] a, b,
                         input logic [AW-1:0] xa, xb);
        item_t it;
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; addr_a = xa; addr_b = xb;
        model(op, a, b, it.res, it.flg);
        it.asum = xa + xb;
        it.op   = op;
        it.req  = req_of(op);
        sb.push_back(it);
    endtask

    task automatic all_ops(input logic [DW-1:0] a, b);
        for (int op = 0; op < 16; op++) begin
            apply(4'(op), a, b, AW'($urandom), AW'($urandom));
        end
    endtask

    // Monitor: the unit is combinational, so the values driven at a negedge
    // are checked at the following posedge.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            if (sb.size() > 0) begin
                it = sb.pop_front();
                n_checks++;
                if (result !== it.res) begin
                    n_fail++;
                    $display("FAIL %s op=%b result act=%h exp=%h", it.req, it.op, result, it.res);
                end
                n_checks++;
                if (flag !== it.flg) begin
                    n_fail++;
                    $display("FAIL %s op=%b flag act=%b exp=%b", it.req, it.op, flag, it.flg);
                end
                n_checks++;
                if (addr_sum !== it.asum) begin
                    n_fail++;
                    $display("FAIL R9 addr_sum act=%h exp=%h", addr_sum, it.asum);
                end
            end
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r1, r2;
        logic [DW-1:0] r1b, r2b;
        // Idle state: all-zero inputs give zero outputs.
        #15;
        n_checks++;
        if (result !== '0 || flag !== 1'b0 || addr_sum !== '0) begin
            n_fail++;
            $display("FAIL R10 idle act=%h/%b/%h exp=0/0/0", result, flag, addr_sum);
        end
        rst_n = 1'b1;

        // Corners: equality, sign boundary, wrap, shifts by 0 and 31.
        all_ops(32'h0, 32'h0);
        all_ops(32'h1234_5678, 32'h1234_5678);               // R2 equal
        all_ops(32'h8000_0000, 32'h7fff_ffff);               // R3 R4 disagree
        all_ops(32'h7fff_ffff, 32'h8000_0000);
        all_ops(32'hffff_ffff, 32'h0000_0001);               // R1 wrap
        all_ops(32'h8000_0001, 32'hffff_ffe0);               // R6 R7 amount 0, high bits ignored
        all_ops(32'h8765_4321, 32'h0000_001f);               // R6 R7 amount 31
        all_ops(32'hf0f0_0f0f, 32'hffff_ff21);               // R5, amount 1
        apply(4'b0000, 32'hffff_f000, 32'h0001_0008, 20'hfffff, 20'h00002); // R1 upper-imm+PC, R9 wrap
        apply(4'b1000, 32'h0, 32'h1, 20'h80000, 20'h80000);  // R2 borrow, R9 wrap to 0

        // Random operands across all codes.
        for (int k = 0; k < 150; k++) begin
            all_ops($urandom, $urandom);
        end

        // R10: replaying identical inputs gives identical outputs.
        for (int k = 0; k < 8; k++) begin
            r1 = $urandom; r2 = $urandom;
            apply(4'(k), r1, r2, 20'h1, 20'h2);
            apply(4'(k + 8), 32'hdead_beef, 32'h5, 20'h3, 20'h4);
            r1b = r1; r2b = r2;
            apply(4'(k), r1b, r2b, 20'h1, 20'h2);
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule